// File: doc/BRIEF.md
# Scan Data-Register Backend for a Test Access Port

This block holds the data-register half of an IEEE 1149.1 test port. It is driven by an external TAP controller. The controller supplies the decoded instruction, the capture, shift and update strobes of the data-register column, and a test-logic-reset level. The TCK and TDI signals come in directly. The block holds four registers:

- a pin-cell scan register that sits between the core and the pads,
- a one-flop bypass stage,
- a 32-bit identification word,
- a user-code word loaded at configuration.

It also exports two user scan chains to core logic and drives the serial output toward TDO.

The instruction code maps to a chain enumeration: `CH_BOUNDARY`, `CH_BYPASS`, `CH_IDENT`, `CH_UCODE`, `CH_USER1` and `CH_USER2`. Every code that is not recognised maps to `CH_BYPASS`. The output driver is a two-state machine clocked on the falling edge of TCK:

- `TDO_IDLE` (driver released) goes to `TDO_DRIVE` when shift is seen.
- `TDO_DRIVE` returns to `TDO_IDLE` when shift ends.
- Reset forces `TDO_IDLE`.

The pin-cell register is laid out with bit 0 at the TDO end, in three groups:

- Bidirectional pins come first. Pin i owns three bits: bit 3i (input), bit 3i+1 (output) and bit 3i+2 (enable).
- Input-only pins follow, with one bit each.
- Output-only pins come last, with three bits each: input readback, output and enable.

Top module: `jtag_dr_backend`

## Requirements
- R1: While `tap_reset` is high, `tdo_en` is 0, the bypass flop is cleared, and every pin-cell update latch is cleared. So selecting EXTEST right after reset drives 0 on all pad outputs and enables.
- R2: `tdo_en` is 1 exactly for the TCK cycles in which `shift_dr` is high, and `tdo` is updated on the falling edge of TCK.
- R3: Instruction codes are decoded as follows:
  - 3'b000 is EXTEST.
  - 3'b001 is IDCODE.
  - 3'b010 is USERCODE.
  - 3'b011 is USER1.
  - 3'b100 is USER2.
  - 3'b111 is BYPASS.
  - Any other code (3'b101, 3'b110) selects the bypass flop.
- R4: The bypass flop loads 0 on capture, so the first bit shifted out is 0. After that, each TDI bit appears on TDO one shift later.
- R5: The identification register captures {version[3:0], family[6:0], rows[8:0], maker[10:0], 1'b1}. It shifts out LSB first, so the first bit is always 1.
- R6: The user-code register captures `usercode` when `config_done` is 1 and all ones otherwise, and shifts out LSB first.
- R7: The pin-cell register is 3·NB + NI + 3·NO bits long, with the bit layout given above. It shifts toward bit 0, and bit 0 is presented first on TDO.
- R8: Capture under EXTEST loads every pin-cell bit in the same edge:
  - each input bit takes its pad input;
  - each output and enable bit takes the value currently driven on the pad;
  - the input bit of an output-only pin takes its driven output value.
- R9: Under EXTEST, the update latches copy the shift stage only on the falling TCK edge of an update cycle. Pad drive values do not change while shifting.
- R10: While the instruction is not EXTEST, pad outputs and enables follow the core's values.
- R11: `user1_sel` / `user2_sel` are high exactly while USER1 / USER2 is loaded, never both at once. While a chain is selected, TDO returns that chain's `userN_tdo` during shift.
- R12: `userN_drck` pulses once per TCK cycle in which its chain is selected and capture or shift is high, and stays low otherwise. `user_tdi`, `user_reset`, `user_shift` and `user_update` are shared by both chains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tap_reset | input | 1 | High while the TAP is in test-logic-reset |
| instr | input | 3 | Current instruction code |
| capture_dr | input | 1 | Capture-DR state strobe |
| shift_dr | input | 1 | Shift-DR state strobe |
| update_dr | input | 1 | Update-DR state strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, valid when tdo_en is high |
| tdo_en | output | 1 | TDO driver enable; low means high impedance |
| usercode | input | 32 | Configuration-time user code |
| config_done | input | 1 | Configuration complete |
| pad_bidir_in | input | NB | Bidirectional pad inputs |
| core_bidir_out | input | NB | Core output values for bidirectional pins |
| core_bidir_oe | input | NB | Core output enables for bidirectional pins |
| pad_bidir_out | output | NB | Output values driven to bidirectional pads |
| pad_bidir_oe | output | NB | Output enables driven to bidirectional pads |
| pad_ionly_in | input | NI | Input-only pad values |
| core_oonly_out | input | NO | Core values for output-only pins |
| core_oonly_oe | input | NO | Core enables for output-only pins |
| pad_oonly_out | output | NO | Values driven to output-only pads |
| pad_oonly_oe | output | NO | Enables driven to output-only pads |
| user1_sel | output | 1 | USER1 loaded |
| user1_drck | output | 1 | Gated clock for user chain 1 |
| user1_tdo | input | 1 | Return data from user chain 1 |
| user2_sel | output | 1 | USER2 loaded |
| user2_drck | output | 1 | Gated clock for user chain 2 |
| user2_tdo | input | 1 | Return data from user chain 2 |
| user_tdi | output | 1 | Shared serial data to user chains |
| user_reset | output | 1 | Shared test-logic-reset status |
| user_shift | output | 1 | Shared shift status |
| user_update | output | 1 | Shared update status |

## Verification
The bench builds the block with three bidirectional pins, two input-only pins and one output-only pin, which gives a 14-bit pin-cell register. This size holds every cell kind at least once and lets a whole register scan stay short. The identification fields are set to non-default values, so a misplaced field or a missing trailing 1 shows up in the shifted word. Scanning the pin-cell register twice means the second capture observes the drive values loaded by the first update. That brings both the bit ordering and the falling-edge update within reach.

// File: rtl/jtag_dr_pkg.sv
package jtag_dr_pkg;

    localparam logic [2:0] OP_EXTEST   = 3'b000;
    localparam logic [2:0] OP_IDCODE   = 3'b001;
    localparam logic [2:0] OP_USERCODE = 3'b010;
    localparam logic [2:0] OP_USER1    = 3'b011;
    localparam logic [2:0] OP_USER2    = 3'b100;
    localparam logic [2:0] OP_BYPASS   = 3'b111;

    typedef enum logic [2:0] {
        CH_BYPASS,
        CH_BOUNDARY,
        CH_IDENT,
        CH_UCODE,
        CH_USER1,
        CH_USER2
    } chain_e;

    typedef enum logic {
        TDO_IDLE,
        TDO_DRIVE
    } tdo_state_e;

    function automatic logic [31:0] pack_ident(
        input logic [3:0]  ver,
        input logic [6:0]  fam,
        input logic [8:0]  rows,
        input logic [10:0] maker
    );
        return {ver, fam, rows, maker, 1'b1};
    endfunction

endpackage

// File: rtl/jtag_capture_shift.sv
module jtag_capture_shift #(
    parameter int W = 32
) (
    input  logic         tck,
    input  logic         tap_reset,
    input  logic         sel,
    input  logic         capture,
    input  logic         shift,
    input  logic         tdi,
    input  logic [W-1:0] cap_val,
    output logic         sout
);

    logic [W-1:0] q;

    generate
        if (W == 1) begin : g_single
            always_ff @(posedge tck) begin
                if (tap_reset)             q <= '0;
                else if (sel && capture)   q <= cap_val;
                else if (sel && shift)     q <= tdi;
            end
        end else begin : g_multi
            always_ff @(posedge tck) begin
                if (tap_reset)             q <= '0;
                else if (sel && capture)   q <= cap_val;
                else if (sel && shift)     q <= {tdi, q[W-1:1]};
            end
        end
    endgenerate

    assign sout = q[0];

    AST_CAP_LOADS: assert property (@(posedge tck) disable iff (tap_reset)
        (sel && capture) |=> (q == $past(cap_val)));  // R5

endmodule

// File: rtl/jtag_boundary.sv
module jtag_boundary #(
    parameter int NB = 4,
    parameter int NI = 2,
    parameter int NO = 2
) (
    input  logic          tck,
    input  logic          tap_reset,
    input  logic          sel,
    input  logic          capture,
    input  logic          shift,
    input  logic          update,
    input  logic          tdi,
    input  logic [NB-1:0] pad_bidir_in,
    input  logic [NI-1:0] pad_ionly_in,
    input  logic [NB-1:0] drv_bidir_out,
    input  logic [NB-1:0] drv_bidir_oe,
    input  logic [NO-1:0] drv_oonly_out,
    input  logic [NO-1:0] drv_oonly_oe,
    output logic          sout,
    output logic [NB-1:0] upd_bidir_out,
    output logic [NB-1:0] upd_bidir_oe,
    output logic [NO-1:0] upd_oonly_out,
    output logic [NO-1:0] upd_oonly_oe
);

    localparam int IN_BASE  = 3 * NB;
    localparam int OUT_BASE = IN_BASE + NI;
    localparam int LEN      = OUT_BASE + 3 * NO;

    logic [LEN-1:0] stage;
    logic [LEN-1:0] cap_vec;

    always_comb begin
        cap_vec = '0;
        for (int i = 0; i < NB; i++) begin
            cap_vec[3*i]     = pad_bidir_in[i];
            cap_vec[3*i + 1] = drv_bidir_out[i];
            cap_vec[3*i + 2] = drv_bidir_oe[i];
        end
        for (int j = 0; j < NI; j++) begin
            cap_vec[IN_BASE + j] = pad_ionly_in[j];
        end
        for (int k = 0; k < NO; k++) begin
            cap_vec[OUT_BASE + 3*k]     = drv_oonly_out[k];
            cap_vec[OUT_BASE + 3*k + 1] = drv_oonly_out[k];
            cap_vec[OUT_BASE + 3*k + 2] = drv_oonly_oe[k];
        end
    end

    always_ff @(posedge tck) begin
        if (tap_reset)             stage <= '0;
        else if (sel && capture)   stage <= cap_vec;
        else if (sel && shift)     stage <= {tdi, stage[LEN-1:1]};
    end

    assign sout = stage[0];

    always_ff @(negedge tck) begin
        if (tap_reset) begin
            upd_bidir_out <= '0;
            upd_bidir_oe  <= '0;
            upd_oonly_out <= '0;
            upd_oonly_oe  <= '0;
        end else if (sel && update) begin
            for (int i = 0; i < NB; i++) begin
                upd_bidir_out[i] <= stage[3*i + 1];
                upd_bidir_oe[i]  <= stage[3*i + 2];
            end
            for (int k = 0; k < NO; k++) begin
                upd_oonly_out[k] <= stage[OUT_BASE + 3*k + 1];
                upd_oonly_oe[k]  <= stage[OUT_BASE + 3*k + 2];
            end
        end
    end

    AST_EXTEST_CAPTURE: assert property (@(posedge tck) disable iff (tap_reset)
        (sel && capture) |=> (stage == $past(cap_vec)));  // R8

    AST_UPDATE_HOLD: assert property (@(negedge tck) disable iff (tap_reset)
        !(sel && update) |=> $stable({upd_bidir_out, upd_bidir_oe, upd_oonly_out, upd_oonly_oe}));  // R9

endmodule

// File: rtl/jtag_user_port.sv
module jtag_user_port (
    input  logic tck,
    input  logic tap_reset,
    input  logic sel,
    input  logic capture,
    input  logic shift,
    output logic drck
);

    logic en_q;

    always_ff @(negedge tck) begin
        if (tap_reset) en_q <= 1'b0;
        else           en_q <= sel && (capture || shift);
    end

    assign drck = tck & en_q;

    AST_DRCK_GATED: assert property (@(posedge tck) disable iff (tap_reset)
        en_q |-> (sel && (capture || shift)));  // R12

endmodule

// File: rtl/jtag_dr_backend.sv
module jtag_dr_backend
    import jtag_dr_pkg::*;
#(
    parameter int          NB         = 4,
    parameter int          NI         = 2,
    parameter int          NO         = 2,
    parameter logic [3:0]  ID_VERSION = 4'h1,
    parameter logic [6:0]  ID_FAMILY  = 7'h0C,
    parameter logic [8:0]  ID_ROWS    = 9'd32,
    parameter logic [10:0] ID_MAKER   = 11'h05B
) (
    input  logic          tck,
    input  logic          tap_reset,
    input  logic [2:0]    instr,
    input  logic          capture_dr,
    input  logic          shift_dr,
    input  logic          update_dr,
    input  logic          tdi,
    output logic          tdo,
    output logic          tdo_en,
    input  logic [31:0]   usercode,
    input  logic          config_done,
    input  logic [NB-1:0] pad_bidir_in,
    input  logic [NB-1:0] core_bidir_out,
    input  logic [NB-1:0] core_bidir_oe,
    output logic [NB-1:0] pad_bidir_out,
    output logic [NB-1:0] pad_bidir_oe,
    input  logic [NI-1:0] pad_ionly_in,
    input  logic [NO-1:0] core_oonly_out,
    input  logic [NO-1:0] core_oonly_oe,
    output logic [NO-1:0] pad_oonly_out,
    output logic [NO-1:0] pad_oonly_oe,
    output logic          user1_sel,
    output logic          user1_drck,
    input  logic          user1_tdo,
    output logic          user2_sel,
    output logic          user2_drck,
    input  logic          user2_tdo,
    output logic          user_tdi,
    output logic          user_reset,
    output logic          user_shift,
    output logic          user_update
);

    localparam logic [31:0] IDENT_WORD = pack_ident(ID_VERSION, ID_FAMILY, ID_ROWS, ID_MAKER);

    chain_e     chain;
    tdo_state_e state_q, state_d;
    logic       serial;
    logic       tdo_q;
    logic       bsr_so, byp_so, id_so, uc_so;
    logic       extest;
    logic [31:0] uc_cap;
    logic [NB-1:0] upd_bidir_out, upd_bidir_oe;
    logic [NO-1:0] upd_oonly_out, upd_oonly_oe;

    // instruction decode
    always_comb begin
        unique case (instr)
            OP_EXTEST:   chain = CH_BOUNDARY;
            OP_IDCODE:   chain = CH_IDENT;
            OP_USERCODE: chain = CH_UCODE;
            OP_USER1:    chain = CH_USER1;
            OP_USER2:    chain = CH_USER2;
            default:     chain = CH_BYPASS;
        endcase
    end

    assign extest    = (chain == CH_BOUNDARY);
    assign user1_sel = (chain == CH_USER1);
    assign user2_sel = (chain == CH_USER2);
    assign uc_cap    = config_done ? usercode : '1;

    // pad drive selection
    assign pad_bidir_out = extest ? upd_bidir_out : core_bidir_out;
    assign pad_bidir_oe  = extest ? upd_bidir_oe  : core_bidir_oe;
    assign pad_oonly_out = extest ? upd_oonly_out : core_oonly_out;
    assign pad_oonly_oe  = extest ? upd_oonly_oe  : core_oonly_oe;

    jtag_boundary #(.NB(NB), .NI(NI), .NO(NO)) u_bsr (
        .tck           (tck),
        .tap_reset     (tap_reset),
        .sel           (extest),
        .capture       (capture_dr),
        .shift         (shift_dr),
        .update        (update_dr),
        .tdi           (tdi),
        .pad_bidir_in  (pad_bidir_in),
        .pad_ionly_in  (pad_ionly_in),
        .drv_bidir_out (pad_bidir_out),
        .drv_bidir_oe  (pad_bidir_oe),
        .drv_oonly_out (pad_oonly_out),
        .drv_oonly_oe  (pad_oonly_oe),
        .sout          (bsr_so),
        .upd_bidir_out (upd_bidir_out),
        .upd_bidir_oe  (upd_bidir_oe),
        .upd_oonly_out (upd_oonly_out),
        .upd_oonly_oe  (upd_oonly_oe)
    );

    jtag_capture_shift #(.W(1)) u_bypass (
        .tck(tck), .tap_reset(tap_reset), .sel(chain == CH_BYPASS),
        .capture(capture_dr), .shift(shift_dr), .tdi(tdi),
        .cap_val(1'b0), .sout(byp_so)
    );

    jtag_capture_shift #(.W(32)) u_ident (
        .tck(tck), .tap_reset(tap_reset), .sel(chain == CH_IDENT),
        .capture(capture_dr), .shift(shift_dr), .tdi(tdi),
        .cap_val(IDENT_WORD), .sout(id_so)
    );

    jtag_capture_shift #(.W(32)) u_ucode (
        .tck(tck), .tap_reset(tap_reset), .sel(chain == CH_UCODE),
        .capture(capture_dr), .shift(shift_dr), .tdi(tdi),
        .cap_val(uc_cap), .sout(uc_so)
    );

    jtag_user_port u_user1 (
        .tck(tck), .tap_reset(tap_reset), .sel(user1_sel),
        .capture(capture_dr), .shift(shift_dr), .drck(user1_drck)
    );

    jtag_user_port u_user2 (
        .tck(tck), .tap_reset(tap_reset), .sel(user2_sel),
        .capture(capture_dr), .shift(shift_dr), .drck(user2_drck)
    );

    assign user_tdi    = tdi;
    assign user_reset  = tap_reset;
    assign user_shift  = shift_dr;
    assign user_update = update_dr;

    // serial output mux
    always_comb begin
        unique case (chain)
            CH_BOUNDARY: serial = bsr_so;
            CH_IDENT:    serial = id_so;
            CH_UCODE:    serial = uc_so;
            CH_USER1:    serial = user1_tdo;
            CH_USER2:    serial = user2_tdo;
            default:     serial = byp_so;
        endcase
    end

    // TDO driver state machine: next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TDO_IDLE:  if (shift_dr)  state_d = TDO_DRIVE;
            TDO_DRIVE: if (!shift_dr) state_d = TDO_IDLE;
            default:   state_d = TDO_IDLE;
        endcase
    end

    // state register
    always_ff @(negedge tck) begin
        if (tap_reset) state_q <= TDO_IDLE;
        else           state_q <= state_d;
    end

    // output register
    always_ff @(negedge tck) begin
        if (tap_reset)     tdo_q <= 1'b0;
        else if (shift_dr) tdo_q <= serial;
    end

    assign tdo    = tdo_q;
    assign tdo_en = (state_q == TDO_DRIVE);

    AST_TDO_RELEASE: assert property (@(posedge tck) disable iff (tap_reset)
        !shift_dr |-> !tdo_en);  // R2

    AST_USER_SEL_EXCL: assert property (@(posedge tck) disable iff (tap_reset)
        $onehot0({user1_sel, user2_sel}));  // R11

endmodule

// File: tb/tb_jtag_dr_backend.sv
module tb_jtag_dr_backend;

    localparam int NB  = 3;
    localparam int NI  = 2;
    localparam int NO  = 1;
    localparam int LEN = 3*NB + NI + 3*NO;
    localparam int OB  = 3*NB + NI;
    localparam logic [31:0] EXP_ID = {4'h3, 7'h15, 9'd40, 11'h0A5, 1'b1};

    logic tck = 1'b0;
    logic tap_reset = 1'b1;
    logic [2:0] instr = 3'b111;
    logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
    logic tdo, tdo_en;
    logic [31:0] usercode = 32'h5EED_C0DE;
    logic config_done = 1'b1;
    logic [NB-1:0] pad_bidir_in = '0, core_bidir_out = '1, core_bidir_oe = '1;
    logic [NB-1:0] pad_bidir_out, pad_bidir_oe;
    logic [NI-1:0] pad_ionly_in = '0;
    logic [NO-1:0] core_oonly_out = '1, core_oonly_oe = '1;
    logic [NO-1:0] pad_oonly_out, pad_oonly_oe;
    logic user1_sel, user1_drck, user2_sel, user2_drck;
    logic user1_tdo = 1'b1, user2_tdo = 1'b0;
    logic user_tdi, user_reset, user_shift, user_update;

    int n_checks = 0;
    int n_fail   = 0;
    int cnt1 = 0, cnt2 = 0;

    always #5 tck = ~tck;
    always @(posedge user1_drck) cnt1++;
    always @(posedge user2_drck) cnt2++;

    jtag_dr_backend #(
        .NB(NB), .NI(NI), .NO(NO),
        .ID_VERSION(4'h3), .ID_FAMILY(7'h15), .ID_ROWS(9'd40), .ID_MAKER(11'h0A5)
    ) dut (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic cap, input logic sh, input logic up, input logic din,
                        output logic so, output logic soe);
        capture_dr = cap; shift_dr = sh; update_dr = up; tdi = din;
        @(negedge tck); #1;
        so = tdo; soe = tdo_en;
        @(posedge tck); #1;
    endtask

    task automatic scan(input logic [2:0] op, input int n, input logic [63:0] tin,
                        input logic upd, output logic [63:0] tout);
        logic so, soe;
        logic en_bad;
        en_bad = 1'b0;
        tout = '0;
        instr = op;
        step(1, 0, 0, 0, so, soe);
        if (soe) en_bad = 1'b1;
        for (int k = 0; k < n; k++) begin
            step(0, 1, 0, tin[k], so, soe);
            tout[k] = so;
            if (!soe) en_bad = 1'b1;
        end
        step(0, 0, upd, 0, so, soe);
        if (soe) en_bad = 1'b1;
        check("R2 tdo_en only in shift", {63'd0, en_bad}, 64'd0);
    endtask

    function automatic logic [63:0] pads_now();
        return {48'd0, pad_oonly_oe, pad_oonly_out, pad_bidir_oe, pad_bidir_out};
    endfunction

    function automatic logic [63:0] pads_from(input logic [LEN-1:0] p);
        logic [NB-1:0] bo, boe;
        logic [NO-1:0] oo, ooe;
        for (int i = 0; i < NB; i++) begin bo[i] = p[3*i+1]; boe[i] = p[3*i+2]; end
        for (int k = 0; k < NO; k++) begin oo[k] = p[OB+3*k+1]; ooe[k] = p[OB+3*k+2]; end
        return {48'd0, ooe, oo, boe, bo};
    endfunction

    task automatic t_reset();
        logic so, soe;
        step(0, 0, 0, 0, so, soe);
        check("R1 tdo_en in reset", {63'd0, soe}, 64'd0);
        check("R10 pads follow core", pads_now(), {48'd0, 1'b1, 1'b1, 3'b111, 3'b111});
        check("R11 no user select", {62'd0, user1_sel, user2_sel}, 64'd0);
        @(posedge tck); #1;
        tap_reset = 1'b0;
        step(0, 0, 0, 0, so, soe);
    endtask

    task automatic t_bypass();
        logic [63:0] tin, tout;
        tin = 64'h0000_0000_0000_B5C3;
        scan(3'b111, 16, tin, 1'b0, tout);
        check("R4 bypass delay", tout[15:0], {tin[14:0], 1'b0});
        scan(3'b101, 16, tin, 1'b0, tout);
        check("R3 code 101 is bypass", tout[15:0], {tin[14:0], 1'b0});
        scan(3'b110, 16, ~tin, 1'b0, tout);
        check("R3 code 110 is bypass", tout[15:0], {~tin[14:0], 1'b0});
    endtask

    task automatic t_ident();
        logic [63:0] tout;
        scan(3'b001, 32, 64'd0, 1'b0, tout);
        check("R5 ident word", tout[31:0], EXP_ID);
        check("R5 ident lsb", {63'd0, tout[0]}, 64'd1);
    endtask

    task automatic t_usercode();
        logic [63:0] tout;
        config_done = 1'b1;
        scan(3'b010, 32, 64'd0, 1'b0, tout);
        check("R6 usercode configured", tout[31:0], 32'h5EED_C0DE);
        config_done = 1'b0;
        scan(3'b010, 32, 64'd0, 1'b0, tout);
        check("R6 usercode unconfigured", tout[31:0], 32'hFFFF_FFFF);
        config_done = 1'b1;
    endtask

    task automatic t_extest();
        logic so, soe;
        logic [63:0] tout;
        logic [LEN-1:0] p, e;
        instr = 3'b000;
        step(0, 0, 0, 0, so, soe);
        check("R1 update latches cleared", pads_now(), 64'd0);
        p = 14'b10_1101_1011_0110;
        scan(3'b000, LEN, {50'd0, p}, 1'b0, tout);
        check("R9 pads held during shift", pads_now(), 64'd0);
        step(0, 0, 1, 0, so, soe);
        check("R9 pads after update", pads_now(), pads_from(p));
        pad_bidir_in = 3'b101;
        pad_ionly_in = 2'b10;
        for (int i = 0; i < NB; i++) begin
            e[3*i] = pad_bidir_in[i]; e[3*i+1] = p[3*i+1]; e[3*i+2] = p[3*i+2];
        end
        for (int j = 0; j < NI; j++) e[3*NB+j] = pad_ionly_in[j];
        for (int k = 0; k < NO; k++) begin
            e[OB+3*k] = p[OB+3*k+1]; e[OB+3*k+1] = p[OB+3*k+1]; e[OB+3*k+2] = p[OB+3*k+2];
        end
        scan(3'b000, LEN, 64'd0, 1'b0, tout);
        check("R8 R7 capture order", tout[LEN-1:0], e);
        instr = 3'b111;
        step(0, 0, 0, 0, so, soe);
        check("R10 pads back to core", pads_now(), {48'd0, 1'b1, 1'b1, 3'b111, 3'b111});
    endtask

    task automatic t_user();
        logic so, soe;
        logic [63:0] tout;
        int c1, c2;
        c1 = cnt1; c2 = cnt2;
        instr = 3'b011;
        step(0, 0, 0, 0, so, soe);
        check("R11 user1 select", {62'd0, user1_sel, user2_sel}, 64'd2);
        check("R12 no drck when idle", cnt1 - c1, 64'd0);
        scan(3'b011, 8, 64'hFF, 1'b0, tout);
        check("R11 user1 return data", tout[7:0], 8'hFF);
        check("R12 user1 drck pulses", cnt1 - c1, 64'd9);
        check("R12 user2 drck quiet", cnt2 - c2, 64'd0);
        c1 = cnt1;
        scan(3'b100, 8, 64'hFF, 1'b0, tout);
        check("R11 user2 return data", tout[7:0], 8'h00);
        check("R12 user2 drck pulses", cnt2 - c2, 64'd9);
        check("R12 user1 drck quiet", cnt1 - c1, 64'd0);
        shift_dr = 1'b1; tdi = 1'b1; #1;
        check("R12 shared strobes", {60'd0, user_tdi, user_shift, user_update, user_reset}, 64'hC);
        shift_dr = 1'b0; tdi = 1'b0;
    endtask

    initial begin : watchdog
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        @(posedge tck); #1;
        t_reset();
        t_bypass();
        t_ident();
        t_usercode();
        t_extest();
        t_user();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule